// File: doc/BRIEF.md
# Configurable Registered/Combinational Output Cell Bank

This block is a bank of output cells placed after a programmable sum-of-products array. Each cell takes one sum-of-products term, an output-enable term and a pad read-back value. Two configuration bits per cell choose the mode. The cell can drive the pad from a D flip-flop or straight from the term, and the value can be active-high or active-low. Each cell also returns a feedback bit to the array.

All cells share one clock, one synchronous preset term and one asynchronous reset term. They also share an active-low power-up reset and a test preload path, which forces chosen values into the flip-flops. Tri-state is modelled as a separate enable output per cell, so the surrounding pad logic owns the high-impedance state.

Top module: `sop_output_cell_bank`

## Requirements
- R1: In registered mode (`cfg_reg_i`=1), each rising clock edge with neither preload nor preset active loads the flip-flop from `sop_i`. The pin shows the flip-flop value when `cfg_inv_i`=0 and its complement when `cfg_inv_i`=1.
- R2: In combinational mode (`cfg_reg_i`=0), `pin_out_o` equals `sop_i` (active-high, `cfg_inv_i`=0) or its complement (active-low, `cfg_inv_i`=1) in the same cycle, with no clock edge needed.
- R3: A rising edge with `preset_i`=1 and `pre_en_i`=0 sets every flip-flop to 1.
- R4: `areset_i`=1 clears every flip-flop at once, without a clock edge. It overrides preset, preload and `sop_i` for as long as it is held.
- R5: While `por_n_i`=0 every flip-flop is 0, so a cell in registered active-low mode drives its pin to 1.
- R6: A rising edge with `pre_en_i`=1 loads `pre_val_i` into the flip-flops. This takes priority over preset and `sop_i`.
- R7: `pin_oe_o` follows `oe_i` per cell, combinationally.
- R8: Feedback `fb_o` is the true flip-flop state in registered mode, whatever the polarity. In combinational mode it is the pad read-back `pin_in_i`, so a disabled pin can serve as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n_i | input | 1 | Power-up reset, active low, asynchronous |
| areset_i | input | 1 | Shared asynchronous reset term |
| preset_i | input | 1 | Shared synchronous preset term |
| pre_en_i | input | 1 | Test preload enable |
| pre_val_i | input | NUM_CELLS | Test preload values |
| sop_i | input | NUM_CELLS | Sum-of-products term per cell |
| oe_i | input | NUM_CELLS | Output-enable term per cell |
| cfg_reg_i | input | NUM_CELLS | 1 = registered, 0 = combinational |
| cfg_inv_i | input | NUM_CELLS | 1 = active-low, 0 = active-high |
| pin_in_i | input | NUM_CELLS | Value seen on the pad |
| pin_out_o | output | NUM_CELLS | Value driven toward the pad |
| pin_oe_o | output | NUM_CELLS | Pad drive enable |
| fb_o | output | NUM_CELLS | Feedback to the logic array |

## Verification
The assertions assume that the reset terms change away from the clock's rising edge. They also assume that the configuration bits are quasi-static, so a mode change is not expected to hold across an edge. The bench changes every input only just after a falling edge. It raises and drops the asynchronous reset in the middle of the low phase. It models the pad as the cell's own drive when enabled and as an external value when disabled.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

    typedef enum logic [1:0] {
        MODE_COMB_HI = 2'b00,
        MODE_COMB_LO = 2'b01,
        MODE_REG_HI  = 2'b10,
        MODE_REG_LO  = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic q;
    } cell_state_t;

    function automatic cell_mode_e make_mode(input logic is_reg, input logic is_inv);
        return cell_mode_e'({is_reg, is_inv});
    endfunction

endpackage

// File: rtl/sop_cell_store.sv
module sop_cell_store
    import sop_cell_pkg::*;
(
    input  logic clk,
    input  logic clr_i,
    input  logic preset_i,
    input  logic pre_en_i,
    input  logic pre_val_i,
    input  logic sop_i,
    output logic q_o
);

    cell_state_t state_d;
    cell_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (pre_en_i) begin
            state_d.q = pre_val_i;
        end else if (preset_i) begin
            state_d.q = 1'b1;
        end else begin
            state_d.q = sop_i;
        end
    end

    always_ff @(posedge clk or posedge clr_i) begin
        if (clr_i) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.q;

    a_r1_capture: assert property (@(posedge clk) disable iff (clr_i)
        (!pre_en_i && !preset_i) |=> (q_o == $past(sop_i)));

    a_r3_preset: assert property (@(posedge clk) disable iff (clr_i)
        (preset_i && !pre_en_i) |=> q_o);

    a_r6_preload: assert property (@(posedge clk) disable iff (clr_i)
        pre_en_i |=> (q_o == $past(pre_val_i)));

    a_r4_clear_holds: assert property (@(posedge clk)
        clr_i |-> !q_o);

endmodule

// File: rtl/sop_cell_outsel.sv
module sop_cell_outsel
    import sop_cell_pkg::*;
(
    input  logic cfg_reg_i,
    input  logic cfg_inv_i,
    input  logic sop_i,
    input  logic q_i,
    input  logic oe_i,
    input  logic pin_in_i,
    output logic pin_out_o,
    output logic pin_oe_o,
    output logic fb_o
);

    cell_mode_e mode;

    always_comb begin
        mode = make_mode(cfg_reg_i, cfg_inv_i);
        unique case (mode)
            MODE_REG_HI: begin pin_out_o = q_i;    fb_o = q_i;      end
            MODE_REG_LO: begin pin_out_o = ~q_i;   fb_o = q_i;      end
            MODE_COMB_HI: begin pin_out_o = sop_i; fb_o = pin_in_i; end
            default:     begin pin_out_o = ~sop_i; fb_o = pin_in_i; end
        endcase
        pin_oe_o = oe_i;
    end

endmodule

// File: rtl/sop_output_cell_bank.sv
module sop_output_cell_bank
    import sop_cell_pkg::*;
#(
    parameter int NUM_CELLS = 4
) (
    input  logic                 clk,
    input  logic                 por_n_i,
    input  logic                 areset_i,
    input  logic                 preset_i,
    input  logic                 pre_en_i,
    input  logic [NUM_CELLS-1:0] pre_val_i,
    input  logic [NUM_CELLS-1:0] sop_i,
    input  logic [NUM_CELLS-1:0] oe_i,
    input  logic [NUM_CELLS-1:0] cfg_reg_i,
    input  logic [NUM_CELLS-1:0] cfg_inv_i,
    input  logic [NUM_CELLS-1:0] pin_in_i,
    output logic [NUM_CELLS-1:0] pin_out_o,
    output logic [NUM_CELLS-1:0] pin_oe_o,
    output logic [NUM_CELLS-1:0] fb_o
);

    localparam int LAST_CELL = NUM_CELLS - 1;

    logic                 clr;
    logic [LAST_CELL:0]   q;

    assign clr = areset_i | ~por_n_i;

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        sop_cell_store u_store (
            .clk       (clk),
            .clr_i     (clr),
            .preset_i  (preset_i),
            .pre_en_i  (pre_en_i),
            .pre_val_i (pre_val_i[i]),
            .sop_i     (sop_i[i]),
            .q_o       (q[i])
        );

        sop_cell_outsel u_outsel (
            .cfg_reg_i (cfg_reg_i[i]),
            .cfg_inv_i (cfg_inv_i[i]),
            .sop_i     (sop_i[i]),
            .q_i       (q[i]),
            .oe_i      (oe_i[i]),
            .pin_in_i  (pin_in_i[i]),
            .pin_out_o (pin_out_o[i]),
            .pin_oe_o  (pin_oe_o[i]),
            .fb_o      (fb_o[i])
        );

        a_r8_fb_state: assert property (@(posedge clk) disable iff (clr)
            cfg_reg_i[i] |-> (fb_o[i] == (pin_out_o[i] ^ cfg_inv_i[i])));

        a_r2_comb_path: assert property (@(posedge clk) disable iff (clr)
            !cfg_reg_i[i] |-> (pin_out_o[i] == (sop_i[i] ^ cfg_inv_i[i])));

        a_r7_enable: assert property (@(posedge clk)
            pin_oe_o[i] == oe_i[i]);

        a_r5_powerup_lo: assert property (@(posedge clk)
            (!por_n_i && cfg_reg_i[i] && cfg_inv_i[i]) |-> pin_out_o[i]);
    end

endmodule

// File: tb/sop_output_cell_bank_tb_top.sv
module sop_output_cell_bank_tb_top;

    localparam int  N      = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC   = 10;

    // {reg, inv, sop, preset, pre_en, pre_val, exp_pin, exp_fb}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_0_1_0_0_0_1_1,  // R1 load 1, active-high
        8'b1_1_0_0_0_0_1_0,  // R1 load 0, active-low
        8'b1_1_1_0_0_0_0_1,  // R1 load 1, active-low
        8'b1_0_0_1_0_0_1_1,  // R3 preset beats sop
        8'b1_1_1_1_1_0_1_0,  // R6 preload 0 beats preset and sop
        8'b1_0_0_0_1_1_1_1,  // R6 preload 1 beats sop
        8'b0_0_1_0_0_0_1_1,  // R2 comb high, R8 fb from pad
        8'b0_1_1_0_0_0_0_0,  // R2 comb low
        8'b0_1_0_0_0_0_1_1,  // R2 comb low, sop 0
        8'b1_0_0_0_0_0_0_0   // R1 load 0, active-high
    };

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         areset = 1'b0;
    logic         preset = 1'b0;
    logic         pre_en = 1'b0;
    logic [N-1:0] pre_val = '0;
    logic [N-1:0] sop = '0;
    logic [N-1:0] oe = '1;
    logic [N-1:0] cfg_reg = '1;
    logic [N-1:0] cfg_inv = '1;
    logic [N-1:0] ext = '0;
    logic [N-1:0] pin_in;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;
    logic [N-1:0] fb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    sop_output_cell_bank #(.NUM_CELLS(N)) dut_i (
        .clk       (clk),
        .por_n_i   (por_n),
        .areset_i  (areset),
        .preset_i  (preset),
        .pre_en_i  (pre_en),
        .pre_val_i (pre_val),
        .sop_i     (sop),
        .oe_i      (oe),
        .cfg_reg_i (cfg_reg),
        .cfg_inv_i (cfg_inv),
        .pin_in_i  (pin_in),
        .pin_out_o (pin_out),
        .pin_oe_o  (pin_oe),
        .fb_o      (fb)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R5: power-up reset, registered active-low drives 1
        sop = '1;
        repeat (2) tick();
        check("R5 pin", pin_out, '1);
        check("R5 fb", fb, '0);
        check("R7 oe", pin_oe, '1);
        por_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            cfg_reg = {N{VEC[v][7]}};
            cfg_inv = {N{VEC[v][6]}};
            sop     = {N{VEC[v][5]}};
            preset  = VEC[v][4];
            pre_en  = VEC[v][3];
            pre_val = {N{VEC[v][2]}};
            tick();
            check($sformatf("R1/R2/R3/R6 vec%0d pin", v), pin_out, {N{VEC[v][1]}});
            check($sformatf("R8 vec%0d fb", v), fb, {N{VEC[v][0]}});
        end
        preset = 1'b0;
        pre_en = 1'b0;

        // R6: per-lane preload pattern
        cfg_reg = '1; cfg_inv = '0;
        pre_en = 1'b1; pre_val = 4'b1010; sop = 4'b0101;
        tick();
        pre_en = 1'b0;
        check("R6 lanes", pin_out, 4'b1010);

        // R2: combinational change without a clock edge
        cfg_reg = '0; cfg_inv = 4'b0011; sop = 4'b0110;
        #1;
        check("R2 no clock", pin_out, 4'b0101);

        // R7 and R8: disabled pin becomes an input
        oe = 4'b0000; ext = 4'b1001;
        #1;
        check("R7 disabled", pin_oe, 4'b0000);
        check("R8 pad input", fb, 4'b1001);
        oe = '1;

        // R4: asynchronous reset mid-cycle, overriding preset
        cfg_reg = '1; cfg_inv = '0; sop = '1;
        tick();
        check("R1 set before reset", pin_out, '1);
        #2;
        areset = 1'b1;
        #1;
        check("R4 immediate clear", pin_out, '0);
        preset = 1'b1;
        tick();
        check("R4 over preset", pin_out, '0);
        #2;
        areset = 1'b0;
        @(negedge clk);
        check("R3 after reset", pin_out, '1);
        preset = 1'b0;

        // R5: power-up reset again, active-low registered
        cfg_inv = '1;
        #2;
        por_n = 1'b0;
        #1;
        check("R5 reassert", pin_out, '1);
        check("R8 state zero", fb, '0);
        tick();
        por_n = 1'b1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule